// File: doc/BRIEF.md
# SYSREF-Aligned Local Multiframe Clock Generator

This block produces the local multiframe clock for the link layer of a receiver whose datapath carries four octets per device-clock beat. A beat counter walks through one multiframe, four octets per cycle, and raises a one-cycle LMFC edge pulse each time it returns to zero. A second one-cycle pulse, the buffer release opportunity, follows the LMFC edge by a programmable number of octets, rounded down to whole beats. Downstream logic uses it to let data out of the elastic buffer at a fixed point in the multiframe.

With SYSREF handling on, the first rising edge of SYSREF after the link is enabled sets the phase of the counter. The LMFC edge then lands a programmable octet offset after that event. Later SYSREF edges do not move the counter. The block only compares their phase with the first one and raises a sticky misalignment flag when they differ. With SYSREF handling off, the counter runs free from the moment the link is enabled. Two sticky flags, detected and misaligned, are cleared by write-1-to-clear strobes and while the link is disabled.

Top module: `lmfc_gen`

## Requirements
- R1: The multiframe is `mf_len_m1_i + 1` octets, a multiple of 4 between 4 and 256. It lasts NB = (`mf_len_m1_i` + 1) / 4 cycles. `lmfc_edge_o` is a one-cycle pulse in the beat where the count is zero, repeating every NB cycles.
- R2: While `link_en_i` is low, the counter holds zero and neither pulse is raised. The first cycle after `link_en_i` is sampled high is an LMFC edge cycle.
- R3: `release_o` is high in the beat whose index equals `buf_dly_i` / 4, rounded down. A delay below 4 makes it coincide with `lmfc_edge_o`.
- R4: `sysref_i` is registered. An event is a registered high that follows a registered low, so the event cycle is the cycle after `sysref_i` is first sampled high. A level that stays high counts once.
- R5: The first event after enable (call its cycle E) re-phases the counter. LMFC edges then fall in the cycles E + `lmfc_ofs_i`/4 + k·NB that come after E, with the offset rounded down and smaller than the multiframe.
- R6: Later events never reload the counter. `sysref_err_o` sets in the cycle after an event whose beat differs from the beat of the first event.
- R7: `sysref_det_o` sets in the cycle after any event and stays set.
- R8: `clr_det_i` and `clr_err_i` clear their flag in the next cycle. An event in the same cycle wins over the clear.
- R9: While `link_en_i` is low, both flags and the record of the first event are cleared, so the next enable re-phases afresh.
- R10: While `sysref_dis_i` is 1, SYSREF events are ignored: no flag sets and the counter runs free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_en_i | input | 1 | Link enable; low holds the counter and flags in reset |
| sysref_i | input | 1 | External SYSREF |
| sysref_dis_i | input | 1 | 1 ignores SYSREF |
| mf_len_m1_i | input | 8 | Octets per multiframe minus 1 |
| lmfc_ofs_i | input | 10 | SYSREF to LMFC offset in octets |
| buf_dly_i | input | 12 | Release delay after LMFC edge in octets |
| clr_det_i | input | 1 | Write-1-to-clear strobe for the detected flag |
| clr_err_i | input | 1 | Write-1-to-clear strobe for the misalignment flag |
| lmfc_edge_o | output | 1 | LMFC edge pulse |
| release_o | output | 1 | Buffer release opportunity pulse |
| sysref_det_o | output | 1 | Sticky SYSREF detected |
| sysref_err_o | output | 1 | Sticky SYSREF misaligned |

## Verification
The assertions check properties that must hold on every cycle. The LMFC pulse lasts one cycle outside a re-phase, and the count wraps to zero after the last beat. Both pulses stay quiet and both flags clear while the link is disabled. The flags stay set until a clear strobe arrives, one held SYSREF level gives a single event, and nothing is detected while SYSREF handling is off. Only the bench scenarios can show the absolute phase, because it depends on the history since enable. They cover the edge position after a SYSREF with each offset, the beat of the release pulse for each delay, whether a later event counts as aligned or misaligned, and the priority of set over clear.

// File: rtl/lmfc_gen_pkg.sv
package lmfc_gen_pkg;
  localparam int unsigned BEAT_SHIFT = 2;  // four octets per beat

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/lmfc_sysref_edge.sv
module lmfc_sysref_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic dis_i,
  input  logic sysref_i,
  output logic event_o
);
  logic sr_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= sysref_i;
      prev_q <= sr_q;
    end
  end

  assign event_o = sr_q & ~prev_q & active_i & ~dis_i;

  // R4: a held level yields one event
  a_r4_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);
endmodule

// File: rtl/lmfc_beat_ctr.sv
module lmfc_beat_ctr #(
  parameter int unsigned BEAT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_en_i,
  input  logic [BEAT_W-1:0] last_i,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] load_val_i,
  input  logic [BEAT_W-1:0] rel_beat_i,
  output logic [BEAT_W-1:0] cnt_o,
  output logic              active_o,
  output logic              edge_o,
  output logic              release_o
);
  logic [BEAT_W-1:0] cnt_q;
  logic              act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!run_en_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= 1'b1;
      if (load_i)
        cnt_q <= load_val_i;
      else if (act_q)
        cnt_q <= (cnt_q == last_i) ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign active_o  = act_q;
  assign edge_o    = act_q && (cnt_q == '0);
  assign release_o = act_q && (cnt_q == rel_beat_i);

  a_r1_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && run_en_i && !load_i && cnt_q == last_i) |=> (cnt_q == '0));

  a_r1_edge_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && !load_i && last_i != '0) |=> !edge_o);
endmodule

// File: rtl/lmfc_sysref_status.sv
module lmfc_sysref_status #(
  parameter int unsigned BEAT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_en_i,
  input  logic              event_i,
  input  logic [BEAT_W-1:0] cnt_i,
  input  logic [BEAT_W-1:0] anchor_i,
  input  logic              clr_det_i,
  input  logic              clr_err_i,
  output logic              load_o,
  output logic              det_o,
  output logic              err_o
);
  logic seen_q, det_q, err_q;

  assign load_o = event_i & ~seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      det_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (!link_en_i) begin
      seen_q <= 1'b0;
      det_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (event_i) begin
      seen_q <= 1'b1;
      det_q  <= 1'b1;
      if (seen_q && cnt_i != anchor_i) err_q <= 1'b1;
      else if (clr_err_i)              err_q <= 1'b0;
    end else begin
      if (clr_det_i) det_q <= 1'b0;
      if (clr_err_i) err_q <= 1'b0;
    end
  end

  assign det_o = det_q;
  assign err_o = err_q;

  a_r9_flags_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_i |=> (!det_o && !err_o));

  a_r7_det_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_o && link_en_i && !clr_det_i) |=> det_o);

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && link_en_i && !clr_err_i) |=> err_o);
endmodule

// File: rtl/lmfc_gen.sv
module lmfc_gen
  import lmfc_gen_pkg::*;
#(
  parameter int unsigned MF_W  = 8,
  parameter int unsigned OFS_W = 10,
  parameter int unsigned DLY_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_en_i,
  input  logic             sysref_i,
  input  logic             sysref_dis_i,
  input  logic [MF_W-1:0]  mf_len_m1_i,
  input  logic [OFS_W-1:0] lmfc_ofs_i,
  input  logic [DLY_W-1:0] buf_dly_i,
  input  logic             clr_det_i,
  input  logic             clr_err_i,
  output logic             lmfc_edge_o,
  output logic             release_o,
  output logic             sysref_det_o,
  output logic             sysref_err_o
);
  localparam int unsigned BEAT_W = max3(MF_W, OFS_W, DLY_W) - BEAT_SHIFT;

  logic [BEAT_W-1:0] last_beat, nb, ofs_beats, rel_beat, anchor, load_val, cnt;
  logic              active, sr_event, load;

  assign last_beat = BEAT_W'(mf_len_m1_i >> BEAT_SHIFT);
  assign nb        = last_beat + 1'b1;
  assign ofs_beats = BEAT_W'(lmfc_ofs_i >> BEAT_SHIFT);
  assign rel_beat  = BEAT_W'(buf_dly_i >> BEAT_SHIFT);

  // beat index the first SYSREF cycle is assigned, so the edge follows by ofs_beats
  assign anchor   = (ofs_beats == '0) ? '0 : nb - ofs_beats;
  assign load_val = (anchor == last_beat) ? '0 : anchor + 1'b1;

  lmfc_sysref_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .dis_i    (sysref_dis_i),
    .sysref_i (sysref_i),
    .event_o  (sr_event)
  );

  lmfc_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_en_i   (link_en_i),
    .last_i     (last_beat),
    .load_i     (load),
    .load_val_i (load_val),
    .rel_beat_i (rel_beat),
    .cnt_o      (cnt),
    .active_o   (active),
    .edge_o     (lmfc_edge_o),
    .release_o  (release_o)
  );

  lmfc_sysref_status #(.BEAT_W(BEAT_W)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_en_i (link_en_i),
    .event_i   (sr_event),
    .cnt_i     (cnt),
    .anchor_i  (anchor),
    .clr_det_i (clr_det_i),
    .clr_err_i (clr_err_i),
    .load_o    (load),
    .det_o     (sysref_det_o),
    .err_o     (sysref_err_o)
  );

  a_r2_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_i |=> (!lmfc_edge_o && !release_o));

  a_r10_sysref_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sysref_dis_i && !sysref_det_o) |=> !sysref_det_o);
endmodule

// File: tb/lmfc_gen_test.sv
module lmfc_gen_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_en = 1'b0, sysref = 1'b0, sysref_dis = 1'b0;
  logic [7:0] mf_len_m1 = 8'd3;
  logic [9:0] lmfc_ofs = '0;
  logic [11:0] buf_dly = '0;
  logic       clr_det = 1'b0, clr_err = 1'b0;
  logic       lmfc_edge, release_p, det, err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lmfc_gen uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .link_en_i    (link_en),
    .sysref_i     (sysref),
    .sysref_dis_i (sysref_dis),
    .mf_len_m1_i  (mf_len_m1),
    .lmfc_ofs_i   (lmfc_ofs),
    .buf_dly_i    (buf_dly),
    .clr_det_i    (clr_det),
    .clr_err_i    (clr_err),
    .lmfc_edge_o  (lmfc_edge),
    .release_o    (release_p),
    .sysref_det_o (det),
    .sysref_err_o (err)
  );

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // ev1/ev2: event cycles counted from the first enabled cycle (0); -1 = none
  task automatic run_case(input int mfk, input int ofs, input int dly, input bit dis,
                          input int ev1, input int ev2, input int ncyc);
    int nb, pe, ph, rb;
    bit moved, exp_det, exp_err;
    nb = mfk / 4;
    pe = (nb - (ofs / 4)) % nb;
    rb = dly / 4;
    @(negedge clk);
    link_en = 1'b0; sysref = 1'b0;
    mf_len_m1 = 8'(mfk - 1); lmfc_ofs = 10'(ofs); buf_dly = 12'(dly); sysref_dis = dis;
    repeat (2) @(negedge clk);
    chk(lmfc_edge, 1'b0, "R2", "edge while disabled");
    chk(release_p, 1'b0, "R2", "release while disabled");
    chk(det, 1'b0, "R9", "det after disable");
    chk(err, 1'b0, "R9", "err after disable");
    link_en = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      @(posedge clk);
      @(negedge clk);
      moved = !dis && ev1 >= 0 && n > ev1;
      ph = moved ? (pe + n - ev1) % nb : n % nb;
      exp_det = !dis && ev1 >= 0 && n > ev1;
      exp_err = !dis && ev2 >= 0 && n > ev2 && ((ev2 - ev1) % nb != 0);
      if (moved) chk(lmfc_edge, ph == 0, "R5", "edge after sysref");
      else       chk(lmfc_edge, ph == 0, "R1", "free-running edge");
      chk(release_p, ph == rb, "R3", "release beat");
      if (dis) chk(det, 1'b0, "R10", "det with sysref off");
      else     chk(det, exp_det, "R7", "det flag");
      chk(err, exp_err, "R6", "err flag");
      // sysref_i high over three periods so the event lands at ev (R4)
      sysref = (ev1 >= 0 && n >= ev1 - 1 && n <= ev1 + 1) ||
               (ev2 >= 0 && n >= ev2 - 1 && n <= ev2 + 1);
    end
    sysref = 1'b0;
  endtask

  task automatic w1c_case();
    @(negedge clk);
    link_en = 1'b0; sysref = 1'b0; sysref_dis = 1'b0;
    mf_len_m1 = 8'd15; lmfc_ofs = '0; buf_dly = '0;
    repeat (2) @(negedge clk);
    link_en = 1'b1;
    for (int n = 0; n <= 21; n++) begin
      @(posedge clk);
      @(negedge clk);
      case (n)
        5:  chk(det, 1'b1, "R7", "det set by event at 2");
        6:  chk(det, 1'b0, "R8", "det cleared by strobe");
        10: begin
              chk(det, 1'b1, "R8", "event wins over clear");
              chk(err, 1'b1, "R6", "misaligned second event");
            end
        11: chk(err, 1'b0, "R8", "err cleared by strobe");
        20: begin
              chk(err, 1'b0, "R4", "held level no new event");
              chk(det, 1'b1, "R4", "det kept under held level");
            end
        21: begin
              chk(det, 1'b0, "R9", "det cleared by disable");
              chk(err, 1'b0, "R9", "err cleared by disable");
            end
        default: ;
      endcase
      sysref  = (n == 1) || (n >= 8);
      clr_det = (n == 5) || (n == 9);
      clr_err = (n == 10);
      link_en = (n < 20);
    end
    sysref = 1'b0; clr_det = 1'b0; clr_err = 1'b0;
  endtask

  initial begin
    int mf_list[6] = '{4, 8, 12, 28, 64, 256};
    repeat (3) @(negedge clk);
    chk(lmfc_edge, 1'b0, "R2", "edge in reset");
    chk(det, 1'b0, "R7", "det in reset");
    rst_n = 1'b1;
    foreach (mf_list[i]) begin
      for (int j = 0; j < 5; j++) begin
        int mfk, ofs, dly, ev1, ev2, nb;
        mfk = mf_list[i];
        nb  = mfk / 4;
        case (j)
          0: ofs = 0;
          1: ofs = 3 % mfk;
          2: ofs = 5 % mfk;
          3: ofs = mfk - 1;
          default: ofs = mfk / 2;
        endcase
        dly = (j * 7) % mfk;
        ev1 = 3 + j;
        ev2 = ev1 + 2 * nb + 4 + (j % 2);
        run_case(mfk, ofs, dly, j == 4, ev1, ev2, ev2 + 2 * nb + 8);
      end
    end
    run_case(16, 8, 4, 1'b0, -1, -1, 20);
    w1c_case();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule